// File: doc/BRIEF.md
# Watermark FIFO with Data-Request Logic

This block sits between a host register port and an I2C byte engine. It holds up to eight bytes. During a write command the host fills the FIFO and the engine drains it toward the bus. During a read command the engine fills it and the host drains it. Two 4-bit watermarks and two residual length counters decide when the block asks the host for attention. The front-end counter tracks engine-side bytes still to move. The back-end counter tracks host-side bytes still to move.

The data-request flag does not follow the FIFO level alone. In the write direction it also depends on how many bytes the host still owes: the request stays off when the remaining free space is too small for the rest of the transfer and the level sits above the low watermark. In the read direction the request turns on when the FIFO reaches the high watermark or when the engine has nothing left to fetch. Host accesses that break the command rules are dropped. They raise one of three sticky error flags, which `err_clr_i` clears. The same strobe also empties the FIFO and zeroes both residuals.

Top module: `wmark_fifo`

## Requirements
- R1: The FIFO stores up to 8 bytes in first-in first-out order. `count_o` reports 0 to 8 entries, and `eng_rdata_o` shows the oldest byte.
- R2: In a write command (`rd_dir_i`=0) the host pushes and the engine pops. In a read command (`rd_dir_i`=1) the engine pushes and the host pops; `host_rdata_o` registers the popped byte. A push and a pop in the same cycle leave the count unchanged.
- R3: While busy in a read command, `hi_water_o` becomes (count ≥ `hi_mark_i`). It holds in any other cycle.
- R4: While busy in a write command, `lo_water_o` becomes (count ≤ `lo_mark_i`). It holds in any other cycle.
- R5: While busy in a read command, `data_req_o` becomes (high-water set and count nonzero) or (front-end residual zero).
- R6: While busy in a write command, `data_req_o` becomes (back-end residual nonzero) and (free entries ≥ back-end residual, or low-water set).
- R7: `data_req_o` holds its value whenever `busy_i` is 0. While busy it is forced to 0 if both residuals are zero. Flags R3–R7 are evaluated on the count and residuals as they stand after the same clock edge.
- R8: A legal host push to a full FIFO, or a legal host pop from an empty one, is dropped. It sets `overrun_err_o` unless `pacing_i` is 1. Fullness is judged on the count before the cycle.
- R9: A host push during a read command, a host pop during a write command, or either access while `busy_i`=0 is dropped and sets `invalid_cmd_o`.
- R10: Each accepted host access decrements the back-end residual by one. If that residual is already zero, the access still moves data, the residual stays zero, and `access_err_o` is set.
- R11: `load_i` sets both residuals to `load_len_i`. Each accepted engine transfer (`eng_ack_o`=1) decrements the front-end residual. The engine is refused when that residual is zero, when it acts against the direction, or when the block is not busy. `err_clr_i` clears all errors, empties the FIFO and zeroes both residuals.
- R12: After reset the count, both residuals, all flags and all errors are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| busy_i | input | 1 | A command is active on the bus |
| rd_dir_i | input | 1 | 1 = read command, 0 = write command |
| pacing_i | input | 1 | Suppresses the overrun error on full/empty host accesses |
| hi_mark_i | input | 4 | High watermark (read direction) |
| lo_mark_i | input | 4 | Low watermark (write direction) |
| load_i | input | 1 | Load both residuals with the command length |
| load_len_i | input | 16 | Command length in bytes |
| err_clr_i | input | 1 | Clear errors, empty FIFO, zero residuals |
| host_wr_i | input | 1 | Host FIFO write strobe |
| host_wdata_i | input | 8 | Host write byte |
| host_rd_i | input | 1 | Host FIFO read strobe |
| host_rdata_o | output | 8 | Last byte popped by the host |
| eng_push_i | input | 1 | Engine delivers a received byte |
| eng_wdata_i | input | 8 | Engine received byte |
| eng_pop_i | input | 1 | Engine takes a byte to transmit |
| eng_rdata_o | output | 8 | Oldest FIFO byte |
| eng_ack_o | output | 1 | Engine transfer accepted this cycle |
| count_o | output | 4 | FIFO entry count |
| hi_water_o | output | 1 | High-water status |
| lo_water_o | output | 1 | Low-water status |
| data_req_o | output | 1 | Data request to the host |
| fe_left_o | output | 16 | Front-end residual |
| be_left_o | output | 16 | Back-end residual |
| overrun_err_o | output | 1 | Sticky host overrun error |
| access_err_o | output | 1 | Sticky access-beyond-length error |
| invalid_cmd_o | output | 1 | Sticky invalid-access error |

## Verification
A host access and an engine transfer can land in the same cycle. In a write command this is a host push with an engine pop; in a read command it is an engine push with a host pop. The vector table provokes both pairs in the middle of a transfer. Each is judged by a count that stays unchanged, by each residual stepping down by exactly one, and by the request flag settling to the value implied by the new residuals, including the cycle where the back-end residual reaches zero.

// File: rtl/wmf_pkg.sv
package wmf_pkg;
  // Sticky error flags; bit order is fixed: {access, overrun, invalid}
  typedef struct packed {
    logic access;
    logic overrun;
    logic invalid;
  } wmf_err_t;
endpackage

// File: rtl/wmf_store.sv
module wmf_store #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] count_next_o,
  output logic          full_o,
  output logic          empty_o
);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          mem_we;

  function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (flush_i) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (push_i) wr_ptr_d = ptr_step(wr_ptr_q);
      if (pop_i)  rd_ptr_d = ptr_step(rd_ptr_q);
      unique case ({push_i, pop_i})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  assign mem_we = push_i && !flush_i;

  always_ff @(posedge clk) begin
    if (mem_we) mem_q[wr_ptr_q] <= push_data_i;
  end

  assign head_o       = mem_q[rd_ptr_q];
  assign count_o      = cnt_q;
  assign count_next_o = cnt_d;
  assign full_o       = (cnt_q == CW'(DEPTH));
  assign empty_o      = (cnt_q == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o); // R1
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o); // R1
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CW'(DEPTH)); // R1
  AST_PAIR_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && pop_i && !flush_i |=> $stable(count_o)); // R2

endmodule

// File: rtl/wmf_host_ctl.sv
module wmf_host_ctl
  import wmf_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     busy_i,
  input  logic     rd_dir_i,
  input  logic     pacing_i,
  input  logic     clr_i,
  input  logic     host_wr_i,
  input  logic     host_rd_i,
  input  logic     full_i,
  input  logic     empty_i,
  input  logic     be_zero_i,
  output logic     host_push_o,
  output logic     host_pop_o,
  output wmf_err_t err_o
);

  logic     wr_wrong, rd_wrong;
  logic     wr_blocked, rd_blocked;
  wmf_err_t err_q, err_d;

  // Direction / activity rule: writes belong to write commands, reads to read commands
  assign wr_wrong   = host_wr_i && (!busy_i || rd_dir_i);
  assign rd_wrong   = host_rd_i && (!busy_i || !rd_dir_i);
  assign wr_blocked = host_wr_i && !wr_wrong && full_i;
  assign rd_blocked = host_rd_i && !rd_wrong && empty_i;

  assign host_push_o = host_wr_i && !wr_wrong && !full_i  && !clr_i;
  assign host_pop_o  = host_rd_i && !rd_wrong && !empty_i && !clr_i;

  always_comb begin
    err_d = err_q;
    if (clr_i) begin
      err_d = '0;
    end else begin
      if (wr_wrong || rd_wrong)                  err_d.invalid = 1'b1;
      if ((wr_blocked || rd_blocked) && !pacing_i) err_d.overrun = 1'b1;
      if ((host_push_o || host_pop_o) && be_zero_i) err_d.access = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= err_d;
  end

  assign err_o = err_q;

  AST_IDLE_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_i && !busy_i && !clr_i |=> err_o.invalid); // R9
  AST_WRONG_DIR_READ_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_i && busy_i && !rd_dir_i && !clr_i |=> err_o.invalid); // R9
  AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_i && full_i |-> !host_push_o); // R8
  AST_OVERRUN_NOT_PACED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o.overrun) |-> !$past(pacing_i)); // R8

endmodule

// File: rtl/wmf_resid.sv
module wmf_resid #(
  parameter int unsigned LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic [LW-1:0] len_i,
  input  logic          fe_dec_i,
  input  logic          be_dec_i,
  output logic [LW-1:0] fe_o,
  output logic [LW-1:0] be_o,
  output logic [LW-1:0] fe_next_o,
  output logic [LW-1:0] be_next_o
);

  logic [LW-1:0] fe_q, fe_d, be_q, be_d;

  always_comb begin
    fe_d = fe_q;
    be_d = be_q;
    if (clr_i) begin
      fe_d = '0;
      be_d = '0;
    end else if (load_i) begin
      fe_d = len_i;
      be_d = len_i;
    end else begin
      if (fe_dec_i && (fe_q != '0)) fe_d = fe_q - 1'b1;
      if (be_dec_i && (be_q != '0)) be_d = be_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fe_q <= '0;
      be_q <= '0;
    end else begin
      fe_q <= fe_d;
      be_q <= be_d;
    end
  end

  assign fe_o      = fe_q;
  assign be_o      = be_q;
  assign fe_next_o = fe_d;
  assign be_next_o = be_d;

  AST_BE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    be_dec_i && (be_o != '0) && !load_i && !clr_i |=> be_o == $past(be_o) - 1'b1); // R10
  AST_BE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    be_dec_i && (be_o == '0) && !load_i && !clr_i |=> be_o == '0); // R10
  AST_LOAD_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    load_i && !clr_i |=> fe_o == be_o); // R11

endmodule

// File: rtl/wmf_req.sv
module wmf_req #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned MW    = 4,
  parameter int unsigned LW    = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy_i,
  input  logic          rd_dir_i,
  input  logic [MW-1:0] hi_mark_i,
  input  logic [MW-1:0] lo_mark_i,
  input  logic [CW-1:0] cnt_n_i,
  input  logic [LW-1:0] fe_n_i,
  input  logic [LW-1:0] be_n_i,
  output logic          hi_o,
  output logic          lo_o,
  output logic          req_o
);

  logic [CW-1:0] free_n;
  logic          hi_calc, lo_calc, room_ok, both_done;
  logic          hi_q, hi_d, lo_q, lo_d, req_q, req_d;
  logic          upd_en;

  assign free_n    = CW'(DEPTH) - cnt_n_i;
  assign hi_calc   = 32'(cnt_n_i) >= 32'(hi_mark_i);
  assign lo_calc   = 32'(cnt_n_i) <= 32'(lo_mark_i);
  assign room_ok   = 32'(free_n)  >= 32'(be_n_i);
  assign both_done = (fe_n_i == '0) && (be_n_i == '0);
  assign upd_en    = busy_i;

  always_comb begin
    hi_d  = hi_q;
    lo_d  = lo_q;
    req_d = req_q;
    if (rd_dir_i) begin
      hi_d  = hi_calc;
      req_d = (hi_calc && (cnt_n_i != '0)) || (fe_n_i == '0);
    end else begin
      lo_d  = lo_calc;
      req_d = (be_n_i != '0) && (room_ok || lo_calc);
    end
    if (both_done) req_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= 1'b0;
      lo_q  <= 1'b0;
      req_q <= 1'b0;
    end else if (upd_en) begin
      hi_q  <= hi_d;
      lo_q  <= lo_d;
      req_q <= req_d;
    end
  end

  assign hi_o  = hi_q;
  assign lo_o  = lo_q;
  assign req_o = req_q;

  AST_REQ_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |=> $stable(req_o)); // R7
  AST_REQ_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i && (fe_n_i == '0) && (be_n_i == '0) |=> !req_o); // R7
  AST_HI_HOLD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i && !rd_dir_i |=> $stable(hi_o)); // R3
  AST_LO_HOLD_READ: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i && rd_dir_i |=> $stable(lo_o)); // R4

endmodule

// File: rtl/wmark_fifo.sv
module wmark_fifo
  import wmf_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 8,
  parameter int unsigned MW    = 4,
  parameter int unsigned LW    = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy_i,
  input  logic          rd_dir_i,
  input  logic          pacing_i,
  input  logic [MW-1:0] hi_mark_i,
  input  logic [MW-1:0] lo_mark_i,
  input  logic          load_i,
  input  logic [LW-1:0] load_len_i,
  input  logic          err_clr_i,
  input  logic          host_wr_i,
  input  logic [DW-1:0] host_wdata_i,
  input  logic          host_rd_i,
  output logic [DW-1:0] host_rdata_o,
  input  logic          eng_push_i,
  input  logic [DW-1:0] eng_wdata_i,
  input  logic          eng_pop_i,
  output logic [DW-1:0] eng_rdata_o,
  output logic          eng_ack_o,
  output logic [CW-1:0] count_o,
  output logic          hi_water_o,
  output logic          lo_water_o,
  output logic          data_req_o,
  output logic [LW-1:0] fe_left_o,
  output logic [LW-1:0] be_left_o,
  output logic          overrun_err_o,
  output logic          access_err_o,
  output logic          invalid_cmd_o
);

  // Reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic          full, empty;
  logic [DW-1:0] head;
  logic [CW-1:0] cnt_next;
  logic [LW-1:0] fe_q, be_q, fe_next, be_next;
  logic          host_push, host_pop;
  logic          eng_take, eng_give;
  logic          st_push, st_pop;
  logic [DW-1:0] st_data;
  wmf_err_t      err;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          rdata_en;

  // Engine side: only in its own direction, while busy, with front-end length left
  assign eng_take = eng_push_i && busy_i && rd_dir_i  && !full  && (fe_q != '0) && !err_clr_i;
  assign eng_give = eng_pop_i  && busy_i && !rd_dir_i && !empty && (fe_q != '0) && !err_clr_i;
  assign eng_ack_o = eng_take || eng_give;

  assign st_push = host_push || eng_take;
  assign st_pop  = host_pop  || eng_give;
  assign st_data = rd_dir_i ? eng_wdata_i : host_wdata_i;

  wmf_host_ctl u_host (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .busy_i      (busy_i),
    .rd_dir_i    (rd_dir_i),
    .pacing_i    (pacing_i),
    .clr_i       (err_clr_i),
    .host_wr_i   (host_wr_i),
    .host_rd_i   (host_rd_i),
    .full_i      (full),
    .empty_i     (empty),
    .be_zero_i   (be_q == '0),
    .host_push_o (host_push),
    .host_pop_o  (host_pop),
    .err_o       (err)
  );

  wmf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .flush_i      (err_clr_i),
    .push_i       (st_push),
    .push_data_i  (st_data),
    .pop_i        (st_pop),
    .head_o       (head),
    .count_o      (count_o),
    .count_next_o (cnt_next),
    .full_o       (full),
    .empty_o      (empty)
  );

  wmf_resid #(.LW(LW)) u_resid (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr_i     (err_clr_i),
    .load_i    (load_i),
    .len_i     (load_len_i),
    .fe_dec_i  (eng_ack_o),
    .be_dec_i  (host_push || host_pop),
    .fe_o      (fe_q),
    .be_o      (be_q),
    .fe_next_o (fe_next),
    .be_next_o (be_next)
  );

  wmf_req #(.DEPTH(DEPTH), .MW(MW), .LW(LW)) u_req (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .busy_i    (busy_i),
    .rd_dir_i  (rd_dir_i),
    .hi_mark_i (hi_mark_i),
    .lo_mark_i (lo_mark_i),
    .cnt_n_i   (cnt_next),
    .fe_n_i    (fe_next),
    .be_n_i    (be_next),
    .hi_o      (hi_water_o),
    .lo_o      (lo_water_o),
    .req_o     (data_req_o)
  );

  // Host read data register, loaded on each accepted host pop
  assign rdata_en = host_pop;
  assign rdata_d  = head;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)    rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

  assign host_rdata_o  = rdata_q;
  assign eng_rdata_o   = head;
  assign fe_left_o     = fe_q;
  assign be_left_o     = be_q;
  assign overrun_err_o = err.overrun;
  assign access_err_o  = err.access;
  assign invalid_cmd_o = err.invalid;

  AST_ENGINE_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({eng_take, eng_give})); // R11
  AST_HOST_POP_DATA: assert property (@(posedge clk) disable iff (!rst_int_n)
    host_pop |=> host_rdata_o == $past(eng_rdata_o)); // R2

endmodule

// File: tb/wmark_fifo_tb.sv
`timescale 1ns/1ps
module wmark_fifo_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        busy, rd_dir, pacing, load, err_clr;
  logic [3:0]  hi_mark, lo_mark;
  logic [15:0] load_len;
  logic        host_wr, host_rd, eng_push, eng_pop;
  logic [7:0]  host_wdata, eng_wdata;
  logic [7:0]  host_rdata, eng_rdata;
  logic        eng_ack;
  logic [3:0]  count;
  logic        hi_water, lo_water, data_req;
  logic [15:0] fe_left, be_left;
  logic        ovr_err, acc_err, inv_err;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk; // 125 MHz

  wmark_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .busy_i(busy), .rd_dir_i(rd_dir), .pacing_i(pacing),
    .hi_mark_i(hi_mark), .lo_mark_i(lo_mark), .load_i(load), .load_len_i(load_len),
    .err_clr_i(err_clr), .host_wr_i(host_wr), .host_wdata_i(host_wdata),
    .host_rd_i(host_rd), .host_rdata_o(host_rdata), .eng_push_i(eng_push),
    .eng_wdata_i(eng_wdata), .eng_pop_i(eng_pop), .eng_rdata_o(eng_rdata),
    .eng_ack_o(eng_ack), .count_o(count), .hi_water_o(hi_water), .lo_water_o(lo_water),
    .data_req_o(data_req), .fe_left_o(fe_left), .be_left_o(be_left),
    .overrun_err_o(ovr_err), .access_err_o(acc_err), .invalid_cmd_o(inv_err)
  );

  typedef struct packed {
    logic       clr;
    logic       ld;
    logic [3:0] len;
    logic       busy;
    logic       rd;
    logic       hwr;
    logic       hrd;
    logic       epush;
    logic       epop;
    logic [3:0] e_cnt;
    logic       e_hi;
    logic       e_lo;
    logic       e_req;
    logic [2:0] e_err; // {access, overrun, invalid}
  } vec_t;

  function automatic vec_t mk(input int c, input int l, input int n, input int b, input int r,
                              input int w, input int d, input int ep, input int eo,
                              input int ec, input int eh, input int el, input int eq,
                              input int ee);
    vec_t v;
    v.clr = 1'(c); v.ld = 1'(l); v.len = 4'(n); v.busy = 1'(b); v.rd = 1'(r);
    v.hwr = 1'(w); v.hrd = 1'(d); v.epush = 1'(ep); v.epop = 1'(eo);
    v.e_cnt = 4'(ec); v.e_hi = 1'(eh); v.e_lo = 1'(el); v.e_req = 1'(eq); v.e_err = 3'(ee);
    return v;
  endfunction

  localparam int NV = 24;
  // hi_mark = 4, lo_mark = 2, pacing = 0
  localparam vec_t VEC [NV] = '{
    //  clr ld len bsy rd wr rd ep eo   cnt hi lo req err
    mk(0, 1, 3, 1, 0, 0, 0, 0, 0,   0, 0, 1, 1, 0),  // load write len 3
    mk(0, 0, 0, 1, 0, 1, 0, 0, 0,   1, 0, 1, 1, 0),
    mk(0, 0, 0, 1, 0, 1, 0, 0, 0,   2, 0, 1, 1, 0),
    mk(0, 0, 0, 1, 0, 1, 0, 0, 1,   2, 0, 1, 0, 0),  // host push + engine pop
    mk(0, 0, 0, 1, 0, 0, 0, 0, 1,   1, 0, 1, 0, 0),
    mk(0, 0, 0, 1, 0, 0, 0, 0, 1,   0, 0, 1, 0, 0),
    mk(0, 0, 0, 1, 0, 1, 0, 0, 0,   1, 0, 1, 0, 4),  // push past length
    mk(0, 0, 0, 1, 0, 0, 1, 0, 0,   1, 0, 1, 0, 5),  // read during write
    mk(1, 0, 0, 1, 0, 0, 0, 0, 0,   0, 0, 1, 0, 0),  // clear
    mk(0, 1, 5, 1, 1, 0, 0, 0, 0,   0, 0, 1, 0, 0),  // load read len 5
    mk(0, 0, 0, 1, 1, 0, 0, 1, 0,   1, 0, 1, 0, 0),
    mk(0, 0, 0, 1, 1, 0, 0, 1, 0,   2, 0, 1, 0, 0),
    mk(0, 0, 0, 1, 1, 0, 0, 1, 0,   3, 0, 1, 0, 0),
    mk(0, 0, 0, 1, 1, 0, 0, 1, 0,   4, 1, 1, 1, 0),
    mk(0, 0, 0, 1, 1, 0, 1, 1, 0,   4, 1, 1, 1, 0),  // engine push + host pop
    mk(0, 0, 0, 1, 1, 0, 1, 0, 0,   3, 0, 1, 1, 0),
    mk(0, 0, 0, 1, 1, 0, 1, 0, 0,   2, 0, 1, 1, 0),
    mk(0, 0, 0, 1, 1, 0, 1, 0, 0,   1, 0, 1, 1, 0),
    mk(0, 0, 0, 1, 1, 0, 1, 0, 0,   0, 0, 1, 0, 0),  // both residuals zero
    mk(0, 0, 0, 1, 1, 0, 1, 0, 0,   0, 0, 1, 0, 2),  // pop from empty
    mk(0, 0, 0, 1, 1, 1, 0, 0, 0,   0, 0, 1, 0, 3),  // write during read
    mk(1, 0, 0, 1, 1, 0, 0, 0, 0,   0, 0, 1, 0, 0),
    mk(0, 0, 0, 0, 1, 1, 0, 0, 0,   0, 0, 1, 0, 1),  // write while idle
    mk(0, 0, 0, 0, 1, 0, 0, 1, 0,   0, 0, 1, 0, 1)   // engine ignored while idle
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulses_off();
    load = 0; err_clr = 0; host_wr = 0; host_rd = 0; eng_push = 0; eng_pop = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; busy = 0; rd_dir = 0; pacing = 0; hi_mark = 4'd4; lo_mark = 4'd2;
    load_len = '0; host_wdata = '0; eng_wdata = '0;
    pulses_off();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R12 reset state
    chk("R12 count", count, 0);
    chk("R12 flags", {hi_water, lo_water, data_req}, 0);
    chk("R12 errors", {acc_err, ovr_err, inv_err}, 0);
    chk("R12 residuals", {fe_left, be_left}, 0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      err_clr = VEC[i].clr; load = VEC[i].ld; load_len = 16'(VEC[i].len);
      busy = VEC[i].busy; rd_dir = VEC[i].rd; host_wr = VEC[i].hwr; host_rd = VEC[i].hrd;
      eng_push = VEC[i].epush; eng_pop = VEC[i].epop;
      host_wdata = 8'(8'h40 + i); eng_wdata = 8'(8'h80 + i);
      tick();
      pulses_off();
      chk($sformatf("R1 R2 count vec %0d", i), count, VEC[i].e_cnt);
      chk($sformatf("R3 hi_water vec %0d", i), hi_water, VEC[i].e_hi);
      chk($sformatf("R4 lo_water vec %0d", i), lo_water, VEC[i].e_lo);
      chk($sformatf("%s R7 data_req vec %0d", VEC[i].rd ? "R5" : "R6", i), data_req, VEC[i].e_req);
      chk($sformatf("R8 R9 R10 errors vec %0d", i), {acc_err, ovr_err, inv_err}, VEC[i].e_err);
    end

    // R1 R11: ordering and residual counting, write direction
    busy = 1; rd_dir = 0; err_clr = 1; tick(); pulses_off();
    load = 1; load_len = 16'd3; tick(); pulses_off();
    chk("R11 load fe", fe_left, 3);
    chk("R11 load be", be_left, 3);
    foreach (VEC[k]) begin end
    host_wr = 1; host_wdata = 8'h11; tick();
    host_wdata = 8'h22; tick();
    host_wdata = 8'h33; tick(); pulses_off();
    chk("R1 head first", eng_rdata, 8'h11);
    eng_pop = 1; #1;
    chk("R11 engine ack", eng_ack, 1);
    tick(); chk("R1 head second", eng_rdata, 8'h22);
    tick(); chk("R1 head third", eng_rdata, 8'h33);
    tick(); pulses_off();
    chk("R11 fe after pops", fe_left, 0);
    eng_pop = 1; #1;
    chk("R11 engine refused at zero", eng_ack, 0);
    pulses_off();

    // R2: read direction data path
    err_clr = 1; tick(); pulses_off();
    rd_dir = 1; load = 1; load_len = 16'd2; tick(); pulses_off();
    eng_push = 1; eng_wdata = 8'hA5; tick();
    eng_wdata = 8'h5A; tick(); pulses_off();
    host_rd = 1; tick(); pulses_off();
    chk("R2 host read first", host_rdata, 8'hA5);
    host_rd = 1; tick(); pulses_off();
    chk("R2 host read second", host_rdata, 8'h5A);

    // R6: space versus remaining length, low watermark 0
    lo_mark = 4'd0; rd_dir = 0;
    err_clr = 1; tick(); pulses_off();
    load = 1; load_len = 16'd3; tick(); pulses_off();
    host_wr = 1; host_wdata = 8'h01; tick(); pulses_off();
    chk("R6 req with room", data_req, 1);
    err_clr = 1; tick(); pulses_off();
    load = 1; load_len = 16'd12; tick(); pulses_off();
    for (int j = 0; j < 4; j++) begin host_wr = 1; host_wdata = 8'(j); tick(); end
    pulses_off();
    chk("R6 no req without room", data_req, 0);
    for (int j = 0; j < 4; j++) begin host_wr = 1; host_wdata = 8'(j); tick(); end
    pulses_off();
    chk("R1 full count", count, 8);

    // R8: overrun on full, then paced
    host_wr = 1; tick(); pulses_off();
    chk("R8 overrun set", ovr_err, 1);
    chk("R8 dropped count", count, 8);
    chk("R8 dropped be", be_left, 4);
    err_clr = 1; tick(); pulses_off();
    load = 1; load_len = 16'd12; tick(); pulses_off();
    for (int j = 0; j < 8; j++) begin host_wr = 1; host_wdata = 8'(j); tick(); end
    pacing = 1; tick(); pulses_off(); pacing = 0;
    chk("R8 paced no error", ovr_err, 0);
    chk("R8 paced count", count, 8);
    chk("R8 paced be", be_left, 4);

    // R7: request holds while idle
    hi_mark = 4'd1; rd_dir = 1;
    err_clr = 1; tick(); pulses_off();
    load = 1; load_len = 16'd2; tick(); pulses_off();
    eng_push = 1; eng_wdata = 8'h77; tick(); pulses_off();
    chk("R5 req at high water", data_req, 1);
    busy = 0; err_clr = 1; tick(); pulses_off();
    chk("R11 clear empties", count, 0);
    chk("R7 req held while idle", data_req, 1);
    chk("R3 hi held while idle", hi_water, 1);
    busy = 1; tick();
    chk("R7 req cleared when done", data_req, 0);

    finish_run();
  end

endmodule